// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands and returns their full-width product. Each multiplier bit gates a copy of the multiplicand to form one partial-product row, and each row sits one position further left than the row before it. A three-stage carry-save tree collapses the eight rows into two. The first stage is a row of 3:2 cells. The second stage is a row of 4:2 compressors and the third a row of 5:2 compressors. Both compressor rows pass lateral carries from each column to the next higher one. A Han-Carlson parallel-prefix adder then adds the last two rows.

The compressor cells are built so that the carries they pass to the next column never depend on the carries they receive. A lateral carry therefore crosses at most one column boundary within a stage and never ripples along the row. A parameter chooses between a registered output and a purely combinational one. In registered mode the product and its valid flag appear one clock after the input strobe.

Top module: `wtree_mul`

## Requirements
- R1: `prod` equals the unsigned product `op_a * op_b` as a 16-bit value for every pair of 8-bit operands.
- R2: With `REG_OUT=1`, the product of operands presented with `in_valid=1` appears on `prod` after the next rising clock edge. `out_valid` equals `in_valid` delayed by one clock.
- R3: With `REG_OUT=1`, `prod` keeps its last captured value across any edge at which `in_valid=0`, whatever the operands do.
- R4: With `REG_OUT=1`, a synchronous active-high `rst` drives `prod` to 0 and `out_valid` to 0 at the next edge, overriding any strobe.
- R5: With `REG_OUT=0`, `prod` equals `op_a * op_b` in the same cycle and `out_valid` follows `in_valid` combinationally.
- R6: The 3:2 cell satisfies x1 + x2 + x3 = s + 2*co for all 8 input combinations.
- R7: The 4:2 cell satisfies x0+x1+x2+x3+cin = sum + 2*(carry + cout) for all 32 combinations, and `cout` does not depend on `cin`.
- R8: The 5:2 cell satisfies x0+..+x4+cin1+cin2 = sum + 2*(carry + cout1 + cout2) for all 128 combinations, and neither `cout1` nor `cout2` depends on `cin1` or `cin2`.
- R9: A zero operand gives a zero product, and 0xFF * 0xFF gives 0xFE01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| prod | output | 2*WIDTH | Product |
| out_valid | output | 1 | Product valid |

## Verification
The bench builds two instances with WIDTH=8, one with REG_OUT=1 and one with REG_OUT=0, on shared inputs. The combinational instance makes it cheap to sweep all 65,536 operand pairs, one per nanosecond step, with no pipeline bookkeeping. The registered instance exposes the one-cycle capture, the hold when the strobe is low, and the reset override. The three compressor cells are also instantiated alone, so that their identities can be checked exhaustively and their outgoing carries can be compared while only the incoming carries toggle.

// File: rtl/wtree_mul_pkg.sv
package wtree_mul_pkg;
  localparam int TREE_ROWS = 8;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/wtree_cells.sv
module fa_cell
  import wtree_mul_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);
  assign s  = fa_sum(a, b, c);
  assign co = fa_carry(a, b, c);
endmodule

module c42_cell (
  input  logic [3:0] x,
  input  logic       cin,
  output logic       sum,
  output logic       carry,
  output logic       cout
);
  logic s1;
  // outgoing lateral carry comes from the first cell only, which never sees cin
  fa_cell u_first  (.a(x[0]), .b(x[1]), .c(x[2]), .s(s1),  .co(cout));
  fa_cell u_second (.a(s1),   .b(x[3]), .c(cin),  .s(sum), .co(carry));
endmodule

module c52_cell (
  input  logic [4:0] x,
  input  logic       cin1,
  input  logic       cin2,
  output logic       sum,
  output logic       carry,
  output logic       cout1,
  output logic       cout2
);
  logic s1, s2;
  // both lateral carries leave before the incoming ones are folded in
  fa_cell u_a (.a(x[0]), .b(x[1]), .c(x[2]), .s(s1),  .co(cout1));
  fa_cell u_b (.a(s1),   .b(x[3]), .c(x[4]), .s(s2),  .co(cout2));
  fa_cell u_c (.a(s2),   .b(cin1), .c(cin2), .s(sum), .co(carry));
endmodule

// File: rtl/wtree_rows.sv
module fa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] r0,
  input  logic [W-1:0] r1,
  input  logic [W-1:0] r2,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] maj;
  for (genvar j = 0; j < W; j++) begin : g_col
    fa_cell u_fa (.a(r0[j]), .b(r1[j]), .c(r2[j]), .s(s[j]), .co(maj[j]));
  end
  assign c = {maj[W-2:0], 1'b0};
  logic unused_top;
  assign unused_top = maj[W-1];
endmodule

module c42_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] r0,
  input  logic [W-1:0] r1,
  input  logic [W-1:0] r2,
  input  logic [W-1:0] r3,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] carry, lat;
  for (genvar j = 0; j < W; j++) begin : g_col
    logic cin_j;
    if (j == 0) begin : g_lsb
      assign cin_j = 1'b0;
    end else begin : g_mid
      assign cin_j = lat[j-1];
    end
    c42_cell u_c42 (
      .x({r3[j], r2[j], r1[j], r0[j]}), .cin(cin_j),
      .sum(s[j]), .carry(carry[j]), .cout(lat[j])
    );
  end
  assign c = {carry[W-2:0], 1'b0};
  logic unused_top;
  assign unused_top = carry[W-1] ^ lat[W-1];
endmodule

module c52_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] r0,
  input  logic [W-1:0] r1,
  input  logic [W-1:0] r2,
  input  logic [W-1:0] r3,
  input  logic [W-1:0] r4,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] carry, lat1, lat2;
  for (genvar j = 0; j < W; j++) begin : g_col
    logic ci1, ci2;
    if (j == 0) begin : g_lsb
      assign ci1 = 1'b0;
      assign ci2 = 1'b0;
    end else begin : g_mid
      assign ci1 = lat1[j-1];
      assign ci2 = lat2[j-1];
    end
    c52_cell u_c52 (
      .x({r4[j], r3[j], r2[j], r1[j], r0[j]}), .cin1(ci1), .cin2(ci2),
      .sum(s[j]), .carry(carry[j]), .cout1(lat1[j]), .cout2(lat2[j])
    );
  end
  assign c = {carry[W-2:0], 1'b0};
  logic unused_top;
  assign unused_top = carry[W-1] ^ lat1[W-1] ^ lat2[W-1];
endmodule

// File: rtl/hc_adder.sv
module hc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  localparam int LG = $clog2(W);
  localparam int NS = LG + 2;

  logic [NS-1:0][W-1:0] gt, pt;

  assign gt[0] = a & b;
  assign pt[0] = a ^ b;

  for (genvar st = 1; st < NS; st++) begin : g_stage
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (st == 1 && (i % 2) == 1) begin : g_pair
        assign gt[st][i] = gt[st-1][i] | (pt[st-1][i] & gt[st-1][i-1]);
        assign pt[st][i] = pt[st-1][i] & pt[st-1][i-1];
      end else if (st > 1 && st <= LG && (i % 2) == 1 && i >= (1 << (st-1))) begin : g_odd
        assign gt[st][i] = gt[st-1][i] | (pt[st-1][i] & gt[st-1][i-(1 << (st-1))]);
        assign pt[st][i] = pt[st-1][i] & pt[st-1][i-(1 << (st-1))];
      end else if (st == NS-1 && (i % 2) == 0 && i >= 2) begin : g_even
        assign gt[st][i] = gt[st-1][i] | (pt[st-1][i] & gt[st-1][i-1]);
        assign pt[st][i] = pt[st-1][i] & pt[st-1][i-1];
      end else begin : g_pass
        assign gt[st][i] = gt[st-1][i];
        assign pt[st][i] = pt[st-1][i];
      end
    end
  end

  assign sum[0] = pt[0][0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign sum[i] = pt[0][i] ^ gt[NS-1][i-1];
  end

  logic unused_top;
  assign unused_top = gt[NS-1][W-1] ^ (^pt[NS-1]);
endmodule

// File: rtl/wtree_mul.sv
module wtree_mul
  import wtree_mul_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] prod,
  output logic               out_valid
);
  localparam int PW = 2 * WIDTH;

  // partial-product matrix: row i is op_a gated by op_b[i], shifted by i
  logic [TREE_ROWS-1:0][PW-1:0] pp;
  for (genvar i = 0; i < TREE_ROWS; i++) begin : g_pp
    if (i < WIDTH) begin : g_live
      assign pp[i] = PW'(op_a & {WIDTH{op_b[i]}}) << i;
    end else begin : g_zero
      assign pp[i] = '0;
    end
  end

  // stage A: 8 rows -> 7
  logic [PW-1:0] sa_s, sa_c;
  fa_row #(.W(PW)) u_stage_a (
    .r0(pp[0]), .r1(pp[1]), .r2(pp[2]), .s(sa_s), .c(sa_c)
  );

  // stage B: 7 rows -> 5
  logic [PW-1:0] sb_s, sb_c;
  c42_row #(.W(PW)) u_stage_b (
    .r0(sa_s), .r1(sa_c), .r2(pp[3]), .r3(pp[4]), .s(sb_s), .c(sb_c)
  );

  // stage C: 5 rows -> 2
  logic [PW-1:0] sc_s, sc_c;
  c52_row #(.W(PW)) u_stage_c (
    .r0(sb_s), .r1(sb_c), .r2(pp[5]), .r3(pp[6]), .r4(pp[7]), .s(sc_s), .c(sc_c)
  );

  logic [PW-1:0] total;
  hc_adder #(.W(PW)) u_final (.a(sc_s), .b(sc_c), .sum(total));

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    logic          vld_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prod_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) prod_q <= total;
      end
    end
    assign prod      = prod_q;
    assign out_valid = vld_q;
  end else begin : g_comb
    assign prod      = total;
    assign out_valid = in_valid;
  end
endmodule

// File: rtl/wtree_mul_chk.sv
module wtree_mul_chk #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic [2*WIDTH-1:0] prod,
  input logic               out_valid
);
  localparam int PW = 2 * WIDTH;

  if (REG_OUT) begin : g_reg
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid)) |->
        (prod == PW'($past(op_a)) * PW'($past(op_b))));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(in_valid)) |-> $stable(prod));

    assert_reset_clear_R4: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (prod == '0 && !out_valid));
  end else begin : g_comb
    assert_comb_product_R5: assert property (@(posedge clk) disable iff (rst)
      prod == PW'(op_a) * PW'(op_b));

    assert_comb_valid_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid == in_valid);
  end
endmodule

bind wtree_mul wtree_mul_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .prod(prod), .out_valid(out_valid)
);

// File: tb/wtree_mul_tb_top.sv
`timescale 1ns/1ps
module wtree_mul_tb_top;
  localparam int WIDTH = 8;
  localparam int PW    = 2 * WIDTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [WIDTH-1:0] op_a = '0, op_b = '0;
  logic [PW-1:0] prod_r, prod_c;
  logic vld_r, vld_c;

  always #2.5 clk = ~clk;

  wtree_mul #(.WIDTH(WIDTH), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .prod(prod_r), .out_valid(vld_r)
  );
  wtree_mul #(.WIDTH(WIDTH), .REG_OUT(1'b0)) dut_comb_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .prod(prod_c), .out_valid(vld_c)
  );

  // standalone cells
  logic fa_a, fa_b, fa_c, fa_s, fa_co;
  fa_cell u_fa (.a(fa_a), .b(fa_b), .c(fa_c), .s(fa_s), .co(fa_co));
  logic [3:0] k4_x; logic k4_cin, k4_sum, k4_carry, k4_cout;
  c42_cell u_k4 (.x(k4_x), .cin(k4_cin), .sum(k4_sum), .carry(k4_carry), .cout(k4_cout));
  logic [4:0] k5_x; logic k5_c1, k5_c2, k5_sum, k5_carry, k5_o1, k5_o2;
  c52_cell u_k5 (.x(k5_x), .cin1(k5_c1), .cin2(k5_c2), .sum(k5_sum),
                 .carry(k5_carry), .cout1(k5_o1), .cout2(k5_o2));

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {op_a, op_b, expected product}
  localparam logic [31:0] VEC [0:9] = '{
    {8'h00, 8'h00, 16'h0000},
    {8'hFF, 8'hFF, 16'hFE01},
    {8'h01, 8'hFF, 16'h00FF},
    {8'h80, 8'h80, 16'h4000},
    {8'h0F, 8'h10, 16'h00F0},
    {8'hAA, 8'h55, 16'h3872},
    {8'h12, 8'h34, 16'h03A8},
    {8'hFF, 8'h00, 16'h0000},
    {8'h7F, 8'h81, 16'h3FFF},
    {8'hC3, 8'h3C, 16'h2DB4}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R4: reset wins over a live strobe
    in_valid = 1'b1; op_a = 8'h5A; op_b = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    check("R4 reset prod", 32'(prod_r), 32'h0);
    check("R4 reset valid", 32'(vld_r), 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;

    // R1/R2/R9: table walk through the registered instance
    for (int k = 0; k < 10; k++) begin
      op_a = VEC[k][31:24]; op_b = VEC[k][23:16]; in_valid = 1'b1;
      #1;
      check("R5 comb same-cycle", 32'(prod_c), 32'(VEC[k][15:0]));
      check("R5 comb valid", 32'(vld_c), 32'h1);
      @(posedge clk); #1;
      check("R2 registered product", 32'(prod_r), 32'(VEC[k][15:0]));
      check("R2 valid after strobe", 32'(vld_r), 32'h1);
    end
    check("R9 max operands", 32'(VEC[1][15:0]), 32'h0000FE01);

    // R3: operands move while strobe is low
    in_valid = 1'b0; op_a = 8'h11; op_b = 8'h22;
    @(posedge clk); #1;
    check("R3 hold product", 32'(prod_r), 32'h2DB4);
    check("R2 valid drops", 32'(vld_r), 32'h0);
    op_a = 8'hFE; op_b = 8'h03;
    @(posedge clk); #1;
    check("R3 hold again", 32'(prod_r), 32'h2DB4);
    check("R5 comb valid low", 32'(vld_c), 32'h0);

    // R9: zero operand on either side
    in_valid = 1'b1; op_a = 8'h00; op_b = 8'hE7;
    @(posedge clk); #1;
    check("R9 zero multiplicand", 32'(prod_r), 32'h0);
    op_a = 8'hE7; op_b = 8'h00;
    @(posedge clk); #1;
    check("R9 zero multiplier", 32'(prod_r), 32'h0);

    // R4: reset mid-run clears a nonzero product
    op_a = 8'hFF; op_b = 8'hFF;
    @(posedge clk); #1;
    check("R1 load before reset", 32'(prod_r), 32'hFE01);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R4 mid-run prod", 32'(prod_r), 32'h0);
    check("R4 mid-run valid", 32'(vld_r), 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;

    // R1: every operand pair on the combinational instance
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        op_a = a[7:0]; op_b = b[7:0];
        #1;
        check("R1 exhaustive", 32'(prod_c), 32'(a * b));
      end
    end

    // R6: 3:2 cell identity
    for (int v = 0; v < 8; v++) begin
      {fa_a, fa_b, fa_c} = v[2:0];
      #1;
      check("R6 fa identity", 32'(fa_s) + 2 * 32'(fa_co), 32'($countones(v[2:0])));
    end

    // R7: 4:2 cell identity and cin independence of cout
    for (int v = 0; v < 16; v++) begin
      logic co0;
      k4_x = v[3:0]; k4_cin = 1'b0;
      #1;
      co0 = k4_cout;
      check("R7 c42 identity cin0", 32'(k4_sum) + 2 * (32'(k4_carry) + 32'(k4_cout)),
            32'($countones(v[3:0])));
      k4_cin = 1'b1;
      #1;
      check("R7 c42 identity cin1", 32'(k4_sum) + 2 * (32'(k4_carry) + 32'(k4_cout)),
            32'($countones(v[3:0])) + 1);
      check("R7 c42 cout independent", 32'(k4_cout), 32'(co0));
    end

    // R8: 5:2 cell identity and independence of outgoing carries
    for (int v = 0; v < 32; v++) begin
      logic o1_ref, o2_ref;
      k5_x = v[4:0]; k5_c1 = 1'b0; k5_c2 = 1'b0;
      #1;
      o1_ref = k5_o1; o2_ref = k5_o2;
      for (int c = 0; c < 4; c++) begin
        {k5_c2, k5_c1} = c[1:0];
        #1;
        check("R8 c52 identity",
              32'(k5_sum) + 2 * (32'(k5_carry) + 32'(k5_o1) + 32'(k5_o2)),
              32'($countones(v[4:0])) + 32'($countones(c[1:0])));
        check("R8 c52 cout1 independent", 32'(k5_o1), 32'(o1_ref));
        check("R8 c52 cout2 independent", 32'(k5_o2), 32'(o2_ref));
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule